// File: doc/BRIEF.md
# NAPOT Address Remapping Unit

This block sits on a bus request path and rewrites request addresses. It holds two programmable regions. Each region has a match value, a remap base and an enable bit. The match value encodes both the size and the location of a naturally aligned power-of-two window. When a request address falls inside an enabled window, the address bits above the window size are replaced by the remap base, and the offset inside the window is kept. Addresses that fall in no window go out unchanged.

The region registers are loaded through a single-cycle write port. The translation itself is combinational: the translated address follows the request address within the same cycle. A system places one instance on the instruction path and another on the data path, so the two paths are programmed independently. A typical use is to let software be linked at one fixed address while the hardware steers its accesses to whichever physical copy is active.

Top module: `addr_remap`

## Requirements
- R1: After reset every region is disabled, so every request address leaves unchanged with `xlatHit` low.
- R2: A match value whose lowest k bits are ones and whose bit k is zero selects a window of 2^(k+1) bytes. The window starts at the match value with those k+1 low bits cleared. An all-ones match value selects the whole address space.
- R3: When no enabled region contains the request, `xlatAddr` equals `reqAddr`, `xlatHit` is 0 and `xlatRegion` is 0.
- R4: On a hit, `xlatAddr` is the winning region's remap base with its window bits cleared, ORed with the window bits of `reqAddr`. Low bits set in the remap base are ignored.
- R5: A region whose enable bit is 0 never matches.
- R6: When the request lies in more than one enabled region, region 0 wins over region 1, and `xlatRegion` reports the winner.
- R7: On a hit, the offset bits of the request are preserved. Bit 0 is always preserved, because the smallest window is 2 bytes.
- R8: The write port uses `cfgWrSel` codes 0 = match value, 1 = remap base, 2 = enable (from `cfgWrData[0]`). The target region is `cfgWrRegion`. A write is sampled at the rising clock edge and affects translations from that edge on. Without a write, a steady request address gives a steady result.
- R9: A write with `cfgWrSel` = 3 changes no region.
- R10: A write to one region leaves every field of the other region unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfgWrEn | input | 1 | Register write strobe |
| cfgWrRegion | input | 1 | Region index for the write |
| cfgWrSel | input | 2 | Field select: 0 match, 1 remap, 2 enable, 3 none |
| cfgWrData | input | 32 | Write data |
| reqAddr | input | 32 | Incoming request address |
| xlatAddr | output | 32 | Translated request address |
| xlatHit | output | 1 | High when an enabled region matched |
| xlatRegion | output | 1 | Index of the winning region (0 on a miss) |

## Verification
On every cycle, the assertions check the following:
- a miss passes the address through and reports region 0;
- a hit keeps bit 0 of the request;
- a hit only ever names an enabled region;
- the output holds still while the address holds still and no write occurs;
- no hit appears right after reset.

Only the bench scenarios can show the rest:
- the exact translated values for different window sizes;
- the all-ones whole-space encoding;
- region 0 winning when windows overlap;
- the cycle in which a write takes effect;
- select code 3 and writes to one region leaving the other region intact.

// File: rtl/addr_remap_pkg.sv
package addr_remap_pkg;

  typedef enum logic [1:0] {
    SEL_MATCH  = 2'd0,
    SEL_REMAP  = 2'd1,
    SEL_ENABLE = 2'd2,
    SEL_NONE   = 2'd3
  } cfgSel_e;

  // Field load strobes sent from control to datapath
  typedef struct packed {
    logic ldMatch;
    logic ldRemap;
    logic ldEnable;
  } remapStrobe_t;

endpackage

// File: rtl/addr_remap_ctrl.sv
module addr_remap_ctrl
  import addr_remap_pkg::*;
#(
  parameter int NUM_REGIONS = 2,
  parameter int IDX_W       = 1
) (
  input  logic                   cfgWrEn,
  input  logic [IDX_W-1:0]       cfgWrRegion,
  input  logic [1:0]             cfgWrSel,
  output remapStrobe_t           strobe,
  output logic [NUM_REGIONS-1:0] regionSel
);

  always_comb begin
    strobe = '0;
    if (cfgWrEn) begin
      unique case (cfgSel_e'(cfgWrSel))
        SEL_MATCH:  strobe.ldMatch  = 1'b1;
        SEL_REMAP:  strobe.ldRemap  = 1'b1;
        SEL_ENABLE: strobe.ldEnable = 1'b1;
        SEL_NONE:   strobe = '0;
      endcase
    end
  end

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_sel
    assign regionSel[i] = cfgWrEn && (cfgWrRegion == IDX_W'(i));
  end

endmodule

// File: rtl/addr_remap_dp.sv
module addr_remap_dp
  import addr_remap_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int NUM_REGIONS = 2,
  parameter int IDX_W       = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  remapStrobe_t           strobe,
  input  logic [NUM_REGIONS-1:0] regionSel,
  input  logic [ADDR_W-1:0]      wrData,
  input  logic [ADDR_W-1:0]      reqAddr,
  output logic [ADDR_W-1:0]      xlatAddr,
  output logic                   xlatHit,
  output logic [IDX_W-1:0]       xlatRegion,
  output logic [NUM_REGIONS-1:0] regionEn
);

  logic [NUM_REGIONS-1:0] hitVec;
  logic [ADDR_W-1:0]      xlatVec [NUM_REGIONS];

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_region
    logic [ADDR_W-1:0] matchQ;
    logic [ADDR_W-1:0] remapQ;
    logic              enQ;
    logic [ADDR_W-1:0] sizeMask;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        matchQ <= '0;
        remapQ <= '0;
        enQ    <= 1'b0;
      end else if (regionSel[i]) begin
        if (strobe.ldMatch)  matchQ <= wrData;
        if (strobe.ldRemap)  remapQ <= wrData;
        if (strobe.ldEnable) enQ    <= wrData[0];
      end
    end

    // trailing ones plus the first zero above them; all ones if no zero
    assign sizeMask   = matchQ ^ (matchQ + ADDR_W'(1));
    assign hitVec[i]  = enQ && ((reqAddr & ~sizeMask) == (matchQ & ~sizeMask));
    assign xlatVec[i] = (remapQ & ~sizeMask) | (reqAddr & sizeMask);
    assign regionEn[i] = enQ;
  end

  // lowest index is applied last and so wins
  always_comb begin
    xlatAddr   = reqAddr;
    xlatHit    = 1'b0;
    xlatRegion = '0;
    for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
      if (hitVec[i]) begin
        xlatAddr   = xlatVec[i];
        xlatHit    = 1'b1;
        xlatRegion = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/addr_remap.sv
module addr_remap
  import addr_remap_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int NUM_REGIONS = 2,
  localparam int IDX_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgWrEn,
  input  logic [IDX_W-1:0]  cfgWrRegion,
  input  logic [1:0]        cfgWrSel,
  input  logic [ADDR_W-1:0] cfgWrData,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic [ADDR_W-1:0] xlatAddr,
  output logic              xlatHit,
  output logic [IDX_W-1:0]  xlatRegion
);

  remapStrobe_t           strobe;
  logic [NUM_REGIONS-1:0] regionSel;
  logic [NUM_REGIONS-1:0] regionEn;

  addr_remap_ctrl #(
    .NUM_REGIONS(NUM_REGIONS),
    .IDX_W      (IDX_W)
  ) u_ctrl (
    .cfgWrEn    (cfgWrEn),
    .cfgWrRegion(cfgWrRegion),
    .cfgWrSel   (cfgWrSel),
    .strobe     (strobe),
    .regionSel  (regionSel)
  );

  addr_remap_dp #(
    .ADDR_W     (ADDR_W),
    .NUM_REGIONS(NUM_REGIONS),
    .IDX_W      (IDX_W)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .regionSel (regionSel),
    .wrData    (cfgWrData),
    .reqAddr   (reqAddr),
    .xlatAddr  (xlatAddr),
    .xlatHit   (xlatHit),
    .xlatRegion(xlatRegion),
    .regionEn  (regionEn)
  );

endmodule

// File: rtl/addr_remap_chk.sv
module addr_remap_chk #(
  parameter int ADDR_W      = 32,
  parameter int NUM_REGIONS = 2,
  parameter int IDX_W       = 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cfgWrEn,
  input logic [ADDR_W-1:0]      reqAddr,
  input logic [ADDR_W-1:0]      xlatAddr,
  input logic                   xlatHit,
  input logic [IDX_W-1:0]       xlatRegion,
  input logic [NUM_REGIONS-1:0] regionEn
);

  p_passthru_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !xlatHit |-> (xlatAddr == reqAddr) && (xlatRegion == '0));

  p_offset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    xlatHit |-> (xlatAddr[0] == reqAddr[0]));

  p_enabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    xlatHit |-> regionEn[xlatRegion]);

  p_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(reqAddr) && !$past(cfgWrEn)) |-> ($stable(xlatAddr) && $stable(xlatHit)));

  p_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !xlatHit);

endmodule

bind addr_remap addr_remap_chk #(
  .ADDR_W     (ADDR_W),
  .NUM_REGIONS(NUM_REGIONS),
  .IDX_W      (IDX_W)
) u_chk (.*);

// File: tb/addr_remap_tb.sv
module addr_remap_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [0:0]  cfgWrRegion = '0;
  logic [1:0]  cfgWrSel = '0;
  logic [31:0] cfgWrData = '0;
  logic [31:0] reqAddr = 32'h1234_5678;
  logic [31:0] xlatAddr;
  logic        xlatHit;
  logic [0:0]  xlatRegion;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  addr_remap u_dut (
    .clk(clk), .rst_n(rst_n), .cfgWrEn(cfgWrEn), .cfgWrRegion(cfgWrRegion),
    .cfgWrSel(cfgWrSel), .cfgWrData(cfgWrData), .reqAddr(reqAddr),
    .xlatAddr(xlatAddr), .xlatHit(xlatHit), .xlatRegion(xlatRegion)
  );

  task automatic check(string req, logic [31:0] expAddr, logic expHit, logic expReg);
    checks++;
    if (xlatAddr !== expAddr || xlatHit !== expHit || xlatRegion !== expReg) begin
      fails++;
      $display("FAIL %s addr=%h hit=%b reg=%0d expected addr=%h hit=%b reg=%0d",
               req, xlatAddr, xlatHit, xlatRegion, expAddr, expHit, expReg);
    end
  endtask

  task automatic cfgWrite(logic region, logic [1:0] sel, logic [31:0] data);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrRegion = region; cfgWrSel = sel; cfgWrData = data;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic probe(string req, logic [31:0] addr, logic [31:0] expAddr,
                       logic expHit, logic expReg);
    reqAddr = addr;
    #1;
    check(req, expAddr, expHit, expReg);
  endtask

  task automatic testReset();
    probe("R1 reset passthrough", 32'h1234_5678, 32'h1234_5678, 1'b0, 1'b0);
    probe("R1 reset passthrough", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0);
  endtask

  task automatic testBasic();
    cfgWrite(1'b0, 2'd0, 32'h2000_0FFF);   // 8 KiB window at 0x2000_0000
    cfgWrite(1'b0, 2'd1, 32'h8000_4000);
    probe("R5 programmed but disabled", 32'h2000_1ABC, 32'h2000_1ABC, 1'b0, 1'b0);
    cfgWrite(1'b0, 2'd2, 32'h0000_0001);
    probe("R4 translate", 32'h2000_1ABC, 32'h8000_5ABC, 1'b1, 1'b0);
    probe("R2 window top", 32'h2000_1FFF, 32'h8000_5FFF, 1'b1, 1'b0);
    probe("R3 above window", 32'h2000_2000, 32'h2000_2000, 1'b0, 1'b0);
    probe("R3 below window", 32'h1FFF_FFFF, 32'h1FFF_FFFF, 1'b0, 1'b0);
    cfgWrite(1'b0, 2'd1, 32'h8000_4FFF);
    probe("R4 remap low bits ignored", 32'h2000_1ABC, 32'h8000_5ABC, 1'b1, 1'b0);
  endtask

  task automatic testSizes();
    cfgWrite(1'b1, 2'd0, 32'h0000_0100);   // 2-byte window at 0x100
    cfgWrite(1'b1, 2'd1, 32'h4000_0000);
    cfgWrite(1'b1, 2'd2, 32'h0000_0001);
    probe("R2 smallest window", 32'h0000_0101, 32'h4000_0001, 1'b1, 1'b1);
    probe("R7 smallest window offset", 32'h0000_0100, 32'h4000_0000, 1'b1, 1'b1);
    probe("R2 outside smallest", 32'h0000_0102, 32'h0000_0102, 1'b0, 1'b0);
    cfgWrite(1'b1, 2'd0, 32'hFFFF_FFFF);   // whole space
    probe("R2 whole space", 32'h5555_5555, 32'h5555_5555, 1'b1, 1'b1);
    probe("R6 region0 over whole space", 32'h2000_0010, 32'h8000_4010, 1'b1, 1'b0);
  endtask

  task automatic testPriority();
    cfgWrite(1'b1, 2'd0, 32'h2000_7FFF);   // 64 KiB window covering region 0
    cfgWrite(1'b1, 2'd1, 32'hC000_0000);
    probe("R6 overlap region0 wins", 32'h2000_1ABC, 32'h8000_5ABC, 1'b1, 1'b0);
    probe("R6 only region1", 32'h2000_4000, 32'hC000_4000, 1'b1, 1'b1);
    cfgWrite(1'b0, 2'd2, 32'h0000_0000);
    probe("R5 region0 disabled", 32'h2000_1ABC, 32'hC000_1ABC, 1'b1, 1'b1);
    cfgWrite(1'b1, 2'd3, 32'h0000_0000);
    probe("R9 sel3 no effect", 32'h2000_1ABC, 32'hC000_1ABC, 1'b1, 1'b1);
  endtask

  task automatic testIndependence();
    cfgWrite(1'b0, 2'd2, 32'h0000_0001);
    cfgWrite(1'b1, 2'd1, 32'hD000_0000);
    probe("R10 region0 kept", 32'h2000_1ABC, 32'h8000_5ABC, 1'b1, 1'b0);
    probe("R10 region1 updated", 32'h2000_4000, 32'hD000_4000, 1'b1, 1'b1);
  endtask

  task automatic testTiming();
    @(negedge clk);
    reqAddr = 32'h2000_4000;
    cfgWrEn = 1'b1; cfgWrRegion = 1'b1; cfgWrSel = 2'd2; cfgWrData = 32'h0;
    #1;
    check("R8 before write edge", 32'hD000_4000, 1'b1, 1'b1);
    @(posedge clk);
    #1;
    check("R8 after write edge", 32'h2000_4000, 1'b0, 1'b0);
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    testReset();
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testBasic();
    testSizes();
    testPriority();
    testIndependence();
    testTiming();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule